// File: doc/BRIEF.md
# Metering Tone Envelope Generator

This block produces a stream of signed sine samples for a subscriber metering tone at either 12 kHz or 16 kHz. It is clocked from a 3.579545 MHz reference. A free-running divider issues one sample strobe every `SAMPLE_DIV` reference clocks. On each strobe a 24-bit phase accumulator advances by an increment chosen by the frequency select input. The upper phase bits address a quarter-wave sine table that is computed when the design elaborates.

The amplitude follows a stepped envelope, so the tone never starts or stops abruptly. Raising the enable makes the envelope climb from silence to full scale in sixteen 2 dB steps. Each step is held for `STEP_SAMPLES` samples, which gives about 4.5 ms per ramp with the defaults. Dropping the enable does not cut the tone: it keeps running through a matching falling tail to silence. A busy flag tells the surrounding logic when the output is anything other than a held zero.

Top module: `spm_tone_env`

## Requirements
- R1: `strobe_o` is high for exactly one clock in every `SAMPLE_DIV` clocks. The first pulse appears `SAMPLE_DIV` clocks after reset is released.
- R2: With `fsel` = 0 the tone is 12 kHz and with `fsel` = 1 it is 16 kHz. The phase increment per sample is round(f · SAMPLE_DIV · 2^24 / 3579545), and the resulting frequency lies within ±14 Hz of nominal.
- R3: Each sample is the sine of the sample's phase, taken before that sample's increment. The upper 8 phase bits p select the value round(32767 · sin(2π(p+0.5)/256)), which is then scaled by the envelope gain. The result is accurate to within 6 LSB.
- R4: The envelope has 16 levels, from 0 dB (index 0) down to −30 dB (index 15) in 2 dB steps. An idle level (index 16) outputs exactly zero.
- R5: While `en` is high, the level moves one step toward 0 dB after every `STEP_SAMPLES` strobes. Starting from idle, the tone reaches full scale after 16 steps.
- R6: After `en` falls, the tone continues and the level moves one step toward idle after every `STEP_SAMPLES` strobes until idle is reached.
- R7: If `en` rises during a falling tail, the level reverses and climbs from its current step without passing through idle. The dwell count within the current step carries over.
- R8: `busy_o` is registered. It is high one clock after `en` is high and stays high until the level is idle with `en` low. Whenever `busy_o` is low, `sample_o` is zero.
- R9: A change of `fsel` while the tone runs alters the increment from the next strobe on, and the accumulated phase is kept.
- R10: On a strobe that leaves the block idle with `en` low, the phase is cleared. Every new burst therefore starts from phase zero.
- R11: After a synchronous reset, `sample_o` = 0, `strobe_o` = 0, `busy_o` = 0, and the envelope is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Tone request; 1 ramps up, 0 ramps down |
| fsel | input | 1 | Frequency select: 0 = 12 kHz, 1 = 16 kHz |
| sample_o | output | SAMPLE_W | Signed sine sample, held between strobes |
| strobe_o | output | 1 | One-clock pulse when a new sample is presented |
| busy_o | output | 1 | High while tone is requested or any ramp/tail runs |

## Verification
The hardest case to reach is a reversal partway through a falling tail. Here the level is somewhere between the two ends and the step dwell counter is mid-count. The stimulus drops `en` long enough for several falling steps, then raises it again. The reference model predicts the exact strobe on which the climb resumes. A second hard case is an enable pulse shorter than one step. It must raise `busy_o` while the output stays at zero, and then let the block fall back to idle.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int LEVELS   = 16;
    localparam int ATT_W    = 5;
    localparam logic [ATT_W-1:0] ATT_IDLE = ATT_W'(LEVELS);

    // pi/2 scaled by 2^30
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // per-sample phase increment, rounded to nearest
    function automatic longint phase_step(longint freq_hz, longint div,
                                          longint ref_hz, int pw);
        longint num;
        num = freq_hz * div * (64'sd1 << pw);
        return (num + ref_hz / 2) / ref_hz;
    endfunction

    // quarter-wave sample at midpoint angle of slot idx, scaled to amp
    function automatic longint quarter_sine(int idx, int slots, longint amp);
        longint x;
        longint x2;
        longint term;
        longint acc;
        x    = ((2 * longint'(idx) + 1) * HALF_PI_Q30) / (2 * longint'(slots));
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 5; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return (acc * amp + (64'sd1 <<< 29)) >>> 30;
    endfunction

    // Q15 gain for 2 dB steps: ratio 10^(-0.1) in Q16 is 52057
    function automatic longint step_gain(int k);
        longint g;
        g = 64'sd32768;
        for (int i = 0; i < k; i++) g = (g * 64'sd52057 + 64'sd32768) >>> 16;
        return g;
    endfunction

endpackage

// File: rtl/spm_phase_gen.sv
module spm_phase_gen #(
    parameter int REF_HZ     = 3579545,
    parameter int SAMPLE_DIV = 56,
    parameter int PHASE_W    = 24,
    parameter int F_LO_HZ    = 12000,
    parameter int F_HI_HZ    = 16000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fsel,
    input  logic               clr_phase,
    output logic               tick_o,
    output logic [PHASE_W-1:0] phase_o
);
    import spm_pkg::*;

    localparam int DIV_W = $clog2(SAMPLE_DIV);
    localparam logic [PHASE_W-1:0] INC_LO =
        PHASE_W'(phase_step(F_LO_HZ, SAMPLE_DIV, REF_HZ, PHASE_W));
    localparam logic [PHASE_W-1:0] INC_HI =
        PHASE_W'(phase_step(F_HI_HZ, SAMPLE_DIV, REF_HZ, PHASE_W));

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic [PHASE_W-1:0] phase;
    } pg_t;

    pg_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.div == DIV_W'(SAMPLE_DIV - 1));
        if (tick) begin
            st_d.div = '0;
            if (clr_phase) st_d.phase = '0;
            else           st_d.phase = st_q.phase + (fsel ? INC_HI : INC_LO);
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick_o  = tick;
    assign phase_o = st_q.phase;

    // a cleared phase on a strobe leaves the accumulator at zero
    assert_phase_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && clr_phase) |=> (phase_o == '0));

    // phase only moves on a strobe
    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase_o));

endmodule

// File: rtl/spm_sine_lut.sv
module spm_sine_lut #(
    parameter int OUT_W    = 16,
    parameter int IDX_BITS = 8
) (
    input  logic [IDX_BITS-1:0]    idx,
    output logic signed [OUT_W-1:0] val_o
);
    import spm_pkg::*;

    localparam int QB      = IDX_BITS - 2;
    localparam int QN      = 1 << QB;
    localparam longint AMP = (64'sd1 <<< (OUT_W - 1)) - 1;

    logic [OUT_W-1:0] qtab [QN];

    for (genvar i = 0; i < QN; i++) begin : g_qtab
        assign qtab[i] = OUT_W'(quarter_sine(i, QN, AMP));
    end

    logic [1:0]    quad;
    logic [QB-1:0] slot;
    logic [QB-1:0] slot_m;
    logic signed [OUT_W-1:0] mag;

    always_comb begin
        quad   = idx[IDX_BITS-1 -: 2];
        slot   = idx[QB-1:0];
        slot_m = quad[0] ? ~slot : slot;
        mag    = $signed(qtab[slot_m]);
        val_o  = quad[1] ? -mag : mag;
    end

endmodule

// File: rtl/spm_env_seq.sv
module spm_env_seq #(
    parameter int STEP_SAMPLES = 18,
    parameter int GAIN_W       = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         tick,
    output logic [spm_pkg::ATT_W-1:0]    att_next_o,
    output logic [GAIN_W-1:0]            gain_o,
    output logic                         idle_next_o
);
    import spm_pkg::*;

    localparam int DW_W = (STEP_SAMPLES > 1) ? $clog2(STEP_SAMPLES) : 1;

    typedef struct packed {
        logic [ATT_W-1:0] att;
        logic [DW_W-1:0]  dwell;
    } env_t;

    env_t st_d, st_q;
    logic [GAIN_W-1:0] gtab [LEVELS+1];

    for (genvar k = 0; k < LEVELS; k++) begin : g_gain
        assign gtab[k] = GAIN_W'(step_gain(k));
    end
    assign gtab[LEVELS] = '0;

    logic go_up, go_dn;

    always_comb begin
        st_d  = st_q;
        go_up = en  && (st_q.att != '0);
        go_dn = !en && (st_q.att != ATT_IDLE);
        if (tick) begin
            if (go_up || go_dn) begin
                if (st_q.dwell == DW_W'(STEP_SAMPLES - 1)) begin
                    st_d.dwell = '0;
                    st_d.att   = go_up ? st_q.att - 1'b1 : st_q.att + 1'b1;
                end else begin
                    st_d.dwell = st_q.dwell + 1'b1;
                end
            end else begin
                st_d.dwell = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.att   <= ATT_IDLE;
            st_q.dwell <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign att_next_o  = st_d.att;
    assign gain_o      = gtab[st_d.att];
    assign idle_next_o = (st_d.att == ATT_IDLE) && !en;

    // level moves by at most one step per change
    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.att) |->
            ((st_q.att == $past(st_q.att) + 1'b1) ||
             (st_q.att + 1'b1 == $past(st_q.att))));

    // level only changes on a strobe
    assert_move_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.att) |-> $past(tick));

    // direction follows the request
    assert_direction_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.att > $past(st_q.att)) |-> !$past(en));

    assert_level_range_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.att <= ATT_IDLE);

endmodule

// File: rtl/spm_tone_env.sv
module spm_tone_env #(
    parameter int REF_HZ       = 3579545,
    parameter int SAMPLE_DIV   = 56,
    parameter int STEP_SAMPLES = 18,
    parameter int PHASE_W      = 24,
    parameter int SAMPLE_W     = 16,
    parameter int LUT_BITS     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       fsel,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic                       strobe_o,
    output logic                       busy_o
);
    import spm_pkg::*;

    localparam int GAIN_W = 16;
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] sample;
        logic                       strobe;
        logic                       busy;
    } out_t;

    out_t st_d, st_q;

    logic               tick;
    logic [PHASE_W-1:0] phase;
    logic [ATT_W-1:0]   att_next;
    logic [GAIN_W-1:0]  gain;
    logic               idle_next;
    logic signed [SAMPLE_W-1:0] lut_val;
    logic signed [PROD_W-1:0]   prod;
    logic signed [PROD_W-1:0]   scaled;

    spm_phase_gen #(
        .REF_HZ(REF_HZ), .SAMPLE_DIV(SAMPLE_DIV), .PHASE_W(PHASE_W),
        .F_LO_HZ(12000), .F_HI_HZ(16000)
    ) u_phase (
        .clk(clk), .rst(rst), .fsel(fsel), .clr_phase(idle_next),
        .tick_o(tick), .phase_o(phase)
    );

    spm_env_seq #(.STEP_SAMPLES(STEP_SAMPLES), .GAIN_W(GAIN_W)) u_env (
        .clk(clk), .rst(rst), .en(en), .tick(tick),
        .att_next_o(att_next), .gain_o(gain), .idle_next_o(idle_next)
    );

    spm_sine_lut #(.OUT_W(SAMPLE_W), .IDX_BITS(LUT_BITS)) u_lut (
        .idx(phase[PHASE_W-1 -: LUT_BITS]), .val_o(lut_val)
    );

    always_comb begin
        st_d        = st_q;
        prod        = PROD_W'(lut_val) * $signed({1'b0, gain});
        scaled      = prod >>> (GAIN_W - 1);
        st_d.strobe = tick;
        st_d.busy   = en || (att_next != ATT_IDLE);
        if (tick) st_d.sample = scaled[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign strobe_o = st_q.strobe;
    assign busy_o   = st_q.busy;

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (sample_o == '0));

    assert_busy_follows_en_R8: assert property (@(posedge clk) disable iff (rst)
        en |=> busy_o);

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

    assert_sample_between_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        !strobe_o |-> $stable(sample_o));

endmodule

// File: tb/spm_tone_env_tb_top.sv
module spm_tone_env_tb_top;

    localparam int    REF  = 3579545;
    localparam int    DIV  = 56;
    localparam int    STEP = 18;
    localparam int    PW   = 24;
    localparam real   PI   = 3.14159265358979;
    localparam real   TOL  = 6.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic fsel = 1'b0;
    logic signed [15:0] sample;
    logic strobe, busy;

    always #4 clk = ~clk;

    spm_tone_env #(.REF_HZ(REF), .SAMPLE_DIV(DIV), .STEP_SAMPLES(STEP)) dut_i (
        .clk(clk), .rst(rst), .en(en), .fsel(fsel),
        .sample_o(sample), .strobe_o(strobe), .busy_o(busy)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag   = "R11";
    bit    done  = 0;
    real   peak  = 0.0;

    function automatic longint inc_for(longint f);
        return (f * DIV * (64'sd1 << PW) + REF / 2) / REF;
    endfunction

    task automatic chk(bit ok, string req, string what, real act, real exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0.2f expected=%0.2f @%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int     m_cnt, m_att, m_dwell;
    longint m_ph;
    bit     m_strobe, m_busy, m_valid = 0;
    real    m_samp;

    function automatic real ideal(longint ph, int a);
        longint p;
        real    r;
        p = ph >> (PW - 8);
        r = $floor(32767.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 256.0) + 0.5);
        return r * $pow(10.0, -real'(a) / 10.0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_att = 16; m_dwell = 0; m_ph = 0;
            m_strobe = 0; m_busy = 0; m_samp = 0.0;
        end else begin
            bit tk, up, dn;
            tk = (m_cnt == DIV - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            if (tk) begin
                up = en && m_att > 0;
                dn = !en && m_att < 16;
                if (up || dn) begin
                    if (m_dwell == STEP - 1) begin
                        m_dwell = 0;
                        m_att = up ? m_att - 1 : m_att + 1;
                    end else m_dwell++;
                end else m_dwell = 0;
                m_samp = (m_att == 16) ? 0.0 : ideal(m_ph, m_att);
                if (m_att == 16 && !en) m_ph = 0;
                else m_ph = (m_ph + inc_for(fsel ? 16000 : 12000)) & ((64'sd1 << PW) - 1);
            end
            m_strobe = tk;
            m_busy = en || (m_att != 16);
        end
        m_valid = 1;
    end

    always @(negedge clk) begin
        if (m_valid && !done) begin
            real d;
            d = real'(sample) - m_samp;
            if (d < 0) d = -d;
            chk(strobe == m_strobe, "R1", "strobe", real'(strobe), real'(m_strobe));
            chk(busy == m_busy, "R8", "busy", real'(busy), real'(m_busy));
            if (m_att == 16)
                chk(sample == 0, "R4", "idle sample", real'(sample), 0.0);
            else
                chk(d <= TOL, tag, "sample", real'(sample), m_samp);
            if (tag == "R3" && (real'(sample) > peak)) peak = real'(sample);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int gap;
        real f;
        cyc(5);
        chk(sample == 0 && strobe == 0 && busy == 0, "R11", "reset outputs",
            real'(sample) + real'(strobe) + real'(busy), 0.0);
        rst = 1'b0;
        // R1: first strobe and spacing
        gap = 0;
        while (!strobe) begin cyc(1); gap++; end
        chk(gap == DIV, "R1", "first strobe delay", real'(gap), real'(DIV));
        gap = 0;
        cyc(1);
        while (!strobe) begin cyc(1); gap++; end
        chk(gap + 1 == DIV, "R1", "strobe period", real'(gap + 1), real'(DIV));
        // R2: frequency accuracy of the rounded increments
        f = real'(inc_for(12000)) * REF / (DIV * 16777216.0);
        chk((f - 12000.0) <= 14.0 && (f - 12000.0) >= -14.0, "R2", "12k freq", f, 12000.0);
        f = real'(inc_for(16000)) * REF / (DIV * 16777216.0);
        chk((f - 16000.0) <= 14.0 && (f - 16000.0) >= -14.0, "R2", "16k freq", f, 16000.0);
        // short enable pulse: busy without output (R8)
        tag = "R8"; en = 1'b1; cyc(500); en = 1'b0; cyc(300);
        chk(busy == 0 && sample == 0, "R8", "short pulse idle", real'(busy), 0.0);
        // rise (R5)
        tag = "R5"; en = 1'b1; cyc(17500);
        // full scale, 12 kHz (R3, R2)
        tag = "R3"; cyc(3000);
        chk(peak >= 32000.0, "R4", "full-scale peak", peak, 32767.0);
        // frequency switch while running (R9)
        tag = "R9"; fsel = 1'b1; cyc(3000); fsel = 1'b0; cyc(1500);
        // partial fall, then reversal (R6, R7)
        tag = "R6"; en = 1'b0; cyc(8000);
        chk(busy == 1, "R6", "tail still running", real'(busy), 1.0);
        tag = "R7"; en = 1'b1; cyc(10000);
        // full tail to idle (R6)
        tag = "R6"; en = 1'b0; cyc(17500);
        chk(busy == 0 && sample == 0, "R6", "tail ended", real'(busy), 0.0);
        // new burst at 16 kHz starts at zero phase (R10)
        tag = "R10"; fsel = 1'b1; cyc(1000); en = 1'b1; cyc(4000);
        en = 1'b0; cyc(6000);
        // reset in the middle of a tail (R11)
        rst = 1'b1; cyc(2);
        chk(sample == 0 && strobe == 0 && busy == 0, "R11", "mid-tail reset",
            real'(sample) + real'(strobe) + real'(busy), 0.0);
        rst = 1'b0; cyc(200);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule